// File: doc/BRIEF.md
# Single-Phase Grid Phase Tracker

This block follows the phase and frequency of a single-phase grid voltage from a stream of signed fixed-point samples. A single-phase waveform has only one axis, so the block makes a second one. The raw sample serves as the alpha axis. A first-order all-pass section, tuned to give a quarter-cycle lag at nominal grid frequency, produces the beta axis. The pair is rotated by the sine and cosine of the current angle estimate into a synchronous d/q pair.

A proportional-integral regulator pushes d to zero. Its output is added to a fixed nominal per-sample phase increment to form the frequency estimate. That estimate is summed into a wrapping phase register, which is the angle estimate. At lock, q carries the signed amplitude of the input. A gain error on the input therefore moves q but leaves d and the angle unchanged.

The block is driven once per sample, nominally at 10 kHz. One strobe brings in one sample. A fixed three-edge pipeline then updates all outputs together and marks them with a one-cycle valid pulse. Angle and frequency use the same scale: 65536 units are one full turn, so the nominal 50 Hz increment at 10 kHz is 328 units per sample.

Top module: `spll_top`

## Requirements
- R1: A synchronous reset forces angleOut, freqOut, dOut, qOut and ampOut to 0 and outValid low. It also clears the all-pass history, the regulator integrator and the phase register. As a result, the first all-zero sample after a reset gives freqOut = 328, angleOut = 328 and dOut = qOut = 0.
- R2: When sampleStb is high at clock edge k, every output is updated at edge k+3. outValid is high for exactly the cycle after edge k+3 and low in the two cycles before it.
- R3: A strobe that arrives while an earlier sample is still in the pipeline is ignored. It produces no extra valid pulse and no extra angle step.
- R4: With an all-zero input, freqOut equals the nominal increment 328 and angleOut advances by 328 per sample, wrapping modulo 65536. After n samples from reset it reads (328·n) mod 65536.
- R5: Rotation uses d = α·cosθ + β·sinθ and q = β·cosθ − α·sinθ, where θ is angleOut/65536 of a turn. For an input A·cos(φ) in the 49–51 Hz range, the loop settles with |d| below A/12. After each update, angleOut lies within 400 units of the phase of the next input sample minus 16384.
- R6: When locked to an input of 49–51 Hz, the mean of freqOut over 200 samples is within 2 units of the input's true per-sample phase increment (65536·f/10000).
- R7: When locked, the mean of qOut is positive and within 6% of the input amplitude A for any A from 6000 to 28000. ampOut equals |qOut|. Lock accuracy (R5) does not depend on A.
- R8: The integrator term is clamped to ±12 units of increment. For any input, including one the loop cannot fully track, freqOut therefore stays within 328 ± (12 + 262 + 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sampleStb | input | 1 | One-cycle strobe marking a new grid sample |
| sampleIn | input | 16 | Signed Q1.15 grid voltage sample |
| angleOut | output | 16 | Angle estimate, 65536 units per turn |
| freqOut | output | 16 | Frequency estimate, phase units per sample |
| dOut | output | 16 | Signed Q1.15 synchronous d value |
| qOut | output | 16 | Signed Q1.15 synchronous q value |
| ampOut | output | 16 | Magnitude of q, amplitude estimate |
| outValid | output | 1 | One-cycle pulse when the outputs update |

## Verification
A corrupted phase register or a leftover integrator value shows up at the ports on the very first sample after a reset. With zero input, angle and frequency are exact integers, so a wrong increment shows as a mismatch within one sample. Errors in the rotation signs, the all-pass coefficient or the quadrant mapping of the sine table take longer to appear. They prevent lock or move the locked angle away from the input phase, and this becomes visible after a few hundred samples as large d, a wrong frequency mean or an angle offset. Pipeline faults show as a valid pulse on the wrong cycle or as an extra angle step when a second strobe arrives while a sample is in flight.

// File: rtl/spll_pkg.sv
package spll_pkg;
  typedef struct packed {
    logic load;      // capture sample, run all-pass
    logic rotate;    // Park rotation into d/q
    logic regulate;  // PI regulator and frequency sum
    logic advance;   // phase step and output update
  } spll_strobe_t;

  typedef logic signed [63:0] wide_t;
endpackage

// File: rtl/spll_ctrl.sv
module spll_ctrl
  import spll_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         sampleStb,
  output spll_strobe_t stb
);
  logic [2:0] stage;
  logic busy;
  logic accept;

  assign busy   = |stage;
  assign accept = sampleStb && !busy;

  always_ff @(posedge clk) begin
    if (rst) stage <= '0;
    else     stage <= {stage[1:0], accept};
  end

  always_comb begin
    stb.load     = accept;
    stb.rotate   = stage[0];
    stb.regulate = stage[1];
    stb.advance  = stage[2];
  end

  // R2: only one pipeline step may run in any cycle
  a_r2_one_step: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.load, stb.rotate, stb.regulate, stb.advance}));

  // R3: a strobe while busy must not start a new rotation next cycle
  a_r3_busy_drop: assert property (@(posedge clk) disable iff (rst)
    (sampleStb && busy) |=> !stb.rotate);
endmodule

// File: rtl/spll_sincos.sv
module spll_sincos #(
  parameter int DW = 16,
  parameter int TB = 8
) (
  input  logic [TB+1:0]        phase,
  output logic signed [DW-1:0] sinV,
  output logic signed [DW-1:0] cosV
);
  localparam int QN = 1 << TB;
  localparam int PEAK = (1 << (DW - 1)) - 1;
  localparam logic [TB:0] QNV = (TB+1)'(QN);

  function automatic logic signed [DW-1:0] qsin(input int k);
    longint kk, n, m, num, den;
    kk = k;
    n = QN;
    m = kk * (2 * n - kk);
    num = 4 * m * PEAK;
    den = 5 * n * n - m;
    return DW'((num + den / 2) / den);
  endfunction

  logic signed [DW-1:0] lut [0:QN];
  for (genvar k = 0; k <= QN; k++) begin : g_lut
    assign lut[k] = qsin(k);
  end

  logic [1:0]  quad;
  logic [TB:0] idxA, idxB;
  logic signed [DW-1:0] vA, vB;

  assign quad = phase[TB+1:TB];
  assign idxA = {1'b0, phase[TB-1:0]};
  assign idxB = QNV - idxA;
  assign vA   = lut[idxA];
  assign vB   = lut[idxB];

  always_comb begin
    case (quad)
      2'd0:    begin sinV = vA;  cosV = vB;  end
      2'd1:    begin sinV = vB;  cosV = -vA; end
      2'd2:    begin sinV = -vA; cosV = -vB; end
      default: begin sinV = -vB; cosV = vA;  end
    endcase
  end
endmodule

// File: rtl/spll_dp.sv
module spll_dp
  import spll_pkg::*;
#(
  parameter int DW   = 16,
  parameter int PW   = 16,
  parameter int TB   = 8,
  parameter int APC  = -31755,
  parameter int FF   = 328,
  parameter int KP   = 262,
  parameter int KI   = 1,
  parameter int ILIM = 12 << 15,
  parameter int IW   = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  spll_strobe_t         stb,
  input  logic signed [DW-1:0] sampleIn,
  output logic [PW-1:0]        angleOut,
  output logic [PW-1:0]        freqOut,
  output logic signed [DW-1:0] dOut,
  output logic signed [DW-1:0] qOut,
  output logic signed [DW-1:0] ampOut,
  output logic                 outValid
);
  localparam int FB   = DW - 1;
  localparam int HALF = 1 << (FB - 1);
  localparam int SMAX = (1 << (DW - 1)) - 1;
  localparam int SMIN = -(1 << (DW - 1));
  localparam int FMAX = (1 << (PW - 1)) - 1;
  localparam int SPAN = (ILIM >>> FB) + KP + 1;

  function automatic wide_t rnd(input wide_t v);
    return (v + wide_t'(HALF)) >>> FB;
  endfunction

  function automatic logic signed [DW-1:0] sat(input wide_t v);
    if (v > wide_t'(SMAX))      return DW'(SMAX);
    else if (v < wide_t'(SMIN)) return DW'(SMIN);
    else                        return DW'(v);
  endfunction

  logic signed [DW-1:0] alpha, beta, dReg, qReg;
  logic signed [IW-1:0] integ;
  logic [PW-1:0]        freqReg, phaseAcc;
  logic signed [DW-1:0] sinV, cosV;

  spll_sincos #(.DW(DW), .TB(TB)) u_sincos (
    .phase(phaseAcc[PW-1 -: TB+2]),
    .sinV (sinV),
    .cosV (cosV)
  );

  logic signed [DW-1:0] betaNext, dNext, qNext, errV, ampNext;
  logic signed [IW-1:0] integNext;
  logic [PW-1:0]        freqNext;
  wide_t integW, freqW;

  always_comb begin
    // all-pass: y = c*(x - yPrev) + xPrev
    betaNext = sat(rnd((wide_t'(sampleIn) - wide_t'(beta)) * wide_t'(APC)) + wide_t'(alpha));
    dNext = sat(rnd(wide_t'(alpha) * wide_t'(cosV)) + rnd(wide_t'(beta) * wide_t'(sinV)));
    qNext = sat(rnd(wide_t'(beta) * wide_t'(cosV)) - rnd(wide_t'(alpha) * wide_t'(sinV)));
    errV  = sat(-wide_t'(dReg));
    integW = wide_t'(integ) + wide_t'(errV) * wide_t'(KI);
    if (integW > wide_t'(ILIM))       integW = wide_t'(ILIM);
    else if (integW < -wide_t'(ILIM)) integW = -wide_t'(ILIM);
    integNext = IW'(integW);
    freqW = wide_t'(FF) + rnd(wide_t'(errV) * wide_t'(KP)) + (wide_t'(integ) >>> FB);
    if (freqW < 0)                    freqW = 0;
    else if (freqW > wide_t'(FMAX))   freqW = wide_t'(FMAX);
    freqNext = PW'(freqW);
    ampNext  = (qReg < 0) ? sat(-wide_t'(qReg)) : qReg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alpha <= '0; beta <= '0; dReg <= '0; qReg <= '0;
      integ <= '0; freqReg <= '0; phaseAcc <= '0;
      freqOut <= '0; dOut <= '0; qOut <= '0; ampOut <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= stb.advance;
      if (stb.load) begin
        alpha <= sampleIn;
        beta  <= betaNext;
      end
      if (stb.rotate) begin
        dReg <= dNext;
        qReg <= qNext;
      end
      if (stb.regulate) begin
        integ   <= integNext;
        freqReg <= freqNext;
      end
      if (stb.advance) begin
        phaseAcc <= phaseAcc + freqReg;
        freqOut  <= freqReg;
        dOut     <= dReg;
        qOut     <= qReg;
        ampOut   <= ampNext;
      end
    end
  end

  assign angleOut = phaseAcc;

  // R8: integrator never leaves its clamp window
  a_r8_integ_clamp: assert property (@(posedge clk) disable iff (rst)
    (wide_t'(integ) <= wide_t'(ILIM)) && (wide_t'(integ) >= -wide_t'(ILIM)));

  // R8: published frequency stays inside feed-forward +/- span
  a_r8_freq_window: assert property (@(posedge clk) disable iff (rst)
    outValid |-> ((int'(freqOut) <= FF + SPAN) && (int'(freqOut) >= FF - SPAN)));

  // R2: valid is a single-cycle pulse
  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R4: angle moves only on an advance step
  a_r4_angle_hold: assert property (@(posedge clk) disable iff (rst)
    !stb.advance |=> $stable(phaseAcc));
endmodule

// File: rtl/spll_top.sv
module spll_top
  import spll_pkg::*;
#(
  parameter int DW   = 16,
  parameter int PW   = 16,
  parameter int TB   = 8,
  parameter int APC  = -31755,
  parameter int FF   = 328,
  parameter int KP   = 262,
  parameter int KI   = 1,
  parameter int ILIM = 12 << 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sampleStb,
  input  logic signed [DW-1:0] sampleIn,
  output logic [PW-1:0]        angleOut,
  output logic [PW-1:0]        freqOut,
  output logic signed [DW-1:0] dOut,
  output logic signed [DW-1:0] qOut,
  output logic signed [DW-1:0] ampOut,
  output logic                 outValid
);
  spll_strobe_t stb;

  spll_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .sampleStb(sampleStb),
    .stb      (stb)
  );

  spll_dp #(
    .DW(DW), .PW(PW), .TB(TB), .APC(APC), .FF(FF),
    .KP(KP), .KI(KI), .ILIM(ILIM), .IW(32)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .sampleIn(sampleIn),
    .angleOut(angleOut),
    .freqOut (freqOut),
    .dOut    (dOut),
    .qOut    (qOut),
    .ampOut  (ampOut),
    .outValid(outValid)
  );
endmodule

// File: tb/spll_top_tb.sv
`timescale 1ns/1ps
module spll_top_tb;
  localparam int FF = 328;
  localparam int SPAN = 12 + 262 + 1;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic sampleStb = 1'b0;
  logic signed [15:0] sampleIn = '0;
  logic [15:0] angleOut, freqOut;
  logic signed [15:0] dOut, qOut, ampOut;
  logic outValid;

  spll_top u_dut (
    .clk(clk), .rst(rst), .sampleStb(sampleStb), .sampleIn(sampleIn),
    .angleOut(angleOut), .freqOut(freqOut), .dOut(dOut), .qOut(qOut),
    .ampOut(ampOut), .outValid(outValid)
  );

  int checks = 0;
  int errors = 0;
  int validMiss = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1; sampleStb = 1'b0; sampleIn = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // called at a negedge; returns at the negedge after the output edge
  task automatic doSample(input int x);
    int v;
    v = (x > 32767) ? 32767 : ((x < -32767) ? -32767 : x);
    sampleIn = 16'(v);
    sampleStb = 1'b1;
    @(negedge clk);
    sampleStb = 1'b0;
    repeat (3) @(negedge clk);
    if (!outValid) validMiss++;
  endtask

  function automatic int wrapErr(input int e);
    return ((e % 65536) + 65536 + 32768) % 65536 - 32768;
  endfunction

  task automatic runTrial(input real hz, input int amp, input int ph0, input string tag);
    real inc, ph, fSum, qSum;
    int maxD, maxE, e, refP;
    doReset();
    validMiss = 0;
    inc = 65536.0 * hz / 10000.0;
    ph = ph0;
    maxD = 0; maxE = 0; fSum = 0.0; qSum = 0.0;
    for (int n = 0; n < 3000; n++) begin
      int x;
      x = int'(amp * $cos(TWO_PI * ph / 65536.0));
      ph = ph + inc;
      if (ph >= 65536.0) ph = ph - 65536.0;
      doSample(x);
      if (n >= 2800) begin
        if ((dOut < 0 ? -int'(dOut) : int'(dOut)) > maxD) maxD = (dOut < 0) ? -int'(dOut) : int'(dOut);
        refP = int'(ph) - 16384;
        e = wrapErr(int'(angleOut) - refP);
        if ((e < 0 ? -e : e) > maxE) maxE = (e < 0) ? -e : e;
        fSum += real'(freqOut);
        qSum += real'(qOut);
      end
    end
    $display("trial %s: hz=%0f amp=%0d maxD=%0d maxAngErr=%0d fMean=%0f qMean=%0f",
             tag, hz, amp, maxD, maxE, fSum / 200.0, qSum / 200.0);
    check(validMiss == 0, "R2", {tag, " valid on every sample"}, validMiss, 0);
    check(maxD < amp / 12, "R5", {tag, " d near zero"}, maxD, amp / 12);
    check(maxE < 400, "R5", {tag, " angle vs input phase"}, maxE, 400);
    check((fSum / 200.0 > inc - 2.0) && (fSum / 200.0 < inc + 2.0), "R6",
          {tag, " mean frequency"}, longint'(fSum / 200.0), longint'(inc));
    check((qSum / 200.0 > 0.94 * amp) && (qSum / 200.0 < 1.06 * amp), "R7",
          {tag, " q tracks amplitude"}, longint'(qSum / 200.0), amp);
    check(int'(ampOut) == ((qOut < 0) ? -int'(qOut) : int'(qOut)), "R7",
          {tag, " amp equals |q|"}, ampOut, (qOut < 0) ? -int'(qOut) : int'(qOut));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int bad, vcnt;
    logic [15:0] a0;
    void'($urandom(32'd4242));
    @(negedge clk);
    doReset();

    // R1: reset state
    check(outValid == 1'b0, "R1", "valid after reset", outValid, 0);
    check(angleOut == 16'd0, "R1", "angle after reset", angleOut, 0);
    check(freqOut == 16'd0 && dOut == 0 && qOut == 0 && ampOut == 0, "R1",
          "freq/d/q/amp after reset", freqOut, 0);

    // R2: exact latency of the valid pulse
    sampleIn = '0; sampleStb = 1'b1;
    @(negedge clk); sampleStb = 1'b0;          // after E0
    @(negedge clk); check(!outValid, "R2", "valid low after E1", outValid, 0);
    @(negedge clk); check(!outValid, "R2", "valid low after E2", outValid, 0);
    @(negedge clk); check(outValid, "R2", "valid high after E3", outValid, 1);
    check(angleOut == 16'(FF), "R4", "angle after first zero sample", angleOut, FF);
    @(negedge clk); check(!outValid, "R2", "valid single cycle", outValid, 0);

    // R4: zero input, exact increment and wrap
    bad = 0;
    for (int n = 2; n <= 210; n++) begin
      doSample(0);
      if (angleOut != 16'((n * FF) % 65536) || freqOut != 16'(FF) || dOut != 0 || qOut != 0) bad++;
      if (n == 200) check(angleOut == 16'(64), "R4", "angle wraps mod 65536", angleOut, 64);
    end
    check(bad == 0, "R4", "zero-input angle sequence", bad, 0);

    // R3: strobe held over a busy cycle counts once
    a0 = angleOut;
    sampleIn = '0; sampleStb = 1'b1;
    @(negedge clk); @(negedge clk); sampleStb = 1'b0;
    vcnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (outValid) vcnt++;
    end
    check(vcnt == 1, "R3", "one valid for overlapping strobes", vcnt, 1);
    check(angleOut == a0 + 16'(FF), "R3", "single angle step", angleOut, a0 + 16'(FF));

    // directed locks (R5, R6, R7)
    runTrial(50.0, 16000, 0, "nominal");
    runTrial(51.0, 12000, 20000, "fast");
    runTrial(49.0, 7000, 41000, "slow_small");
    runTrial(50.0, 26000, 9000, "large");

    // R1: reset after a locked run clears filter, integrator and phase
    doReset();
    check(angleOut == 0 && freqOut == 0, "R1", "outputs cleared mid-run", angleOut, 0);
    doSample(0);
    check(freqOut == 16'(FF), "R1", "integrator cleared", freqOut, FF);
    check(angleOut == 16'(FF), "R1", "phase cleared", angleOut, FF);
    check(dOut == 0 && qOut == 0, "R1", "filter history cleared", dOut, 0);

    // constrained random trials (R5, R6, R7)
    for (int t = 0; t < 3; t++) begin
      real hz;
      int amp, ph0;
      hz = 49.0 + real'($urandom % 201) / 100.0;
      amp = 6000 + int'($urandom % 22001);
      ph0 = int'($urandom % 65536);
      runTrial(hz, amp, ph0, $sformatf("rand%0d", t));
    end

    // R8: frequency window under a far-off input
    doReset();
    begin
      real ph;
      ph = 0.0; bad = 0;
      for (int n = 0; n < 1500; n++) begin
        doSample(int'(16000 * $cos(TWO_PI * ph / 65536.0)));
        ph = ph + 65536.0 * 56.0 / 10000.0;
        if (ph >= 65536.0) ph = ph - 65536.0;
        if (int'(freqOut) > FF + SPAN || int'(freqOut) < FF - SPAN) bad++;
      end
    end
    check(bad == 0, "R8", "frequency inside clamp window", bad, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule